// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit up-counting timer that turns two compare values into a periodic rectangular waveform on a single pin. A period value sets how long each cycle lasts. When the counter reaches the period value, it returns to zero on the following count-clock tick. A duty value marks the point inside the cycle where the waveform changes level. The output is kept in a toggle flip-flop. That flip-flop inverts every time the counter steps onto either compare value, so the pulse width is a difference of the two values and not the result of a level comparison.

Before counting starts, software chooses three things: the starting level of the flip-flop, whether the pin is driven at all, and which prescaled version of the system clock advances the counter. Two single-cycle interrupt pulses are raised, one for a match with the duty value and one for a match with the period value. The live count is always visible on an output port. Valid settings keep the duty value strictly below the period value.

Top module: `ppg_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `count` is 0 and `pulse_out`, `irq_duty` and `irq_period` are 0.
- R2: While `run` is 1, `count` rises by one on each count-clock tick. On the tick after `count` has reached `period_val`, it returns to 0, so a cycle lasts `period_val`+1 ticks. Between ticks `count` holds its value.
- R3: A `clk_sel` value s produces one count-clock tick every 4^s system clocks (0 gives 1, 1 gives 4, 2 gives 16, 3 gives 64). The tick phase restarts when `run` rises.
- R4: The output flip-flop inverts on each tick that moves `count` onto `duty_val` or onto `period_val`. After a duty match the level is the inverse of `init_level`; after a period match it equals `init_level`. The level that follows a duty match holds for `period_val`−`duty_val` ticks.
- R5: `irq_duty` is high for exactly one system clock, in the cycle where `count` has just stepped onto `duty_val`. `irq_period` behaves the same way for `period_val`.
- R6: Matches count only on a tick that advances the counter. With `duty_val`=0, the zero count present when `run` rises triggers nothing, so the first event after starting is the period match.
- R7: While `run` is 0, `count` is held at 0, no interrupt is raised, and the flip-flop is loaded with `init_level`.
- R8: `pulse_out` follows the flip-flop while `out_en` is 1 and is 0 while `out_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable; 0 stops the counter and reloads it |
| clk_sel | input | 2 | Count-clock prescale select (divide by 4^clk_sel) |
| period_val | input | 16 | Period compare value |
| duty_val | input | 16 | Duty compare value, below `period_val` |
| init_level | input | 1 | Flip-flop level loaded while stopped |
| out_en | input | 1 | Pin drive enable |
| count | output | 16 | Live counter value |
| pulse_out | output | 1 | Generated waveform |
| irq_duty | output | 1 | One-cycle pulse on a duty match |
| irq_period | output | 1 | One-cycle pulse on a period match |

## Verification
On every cycle, the embedded assertions check these counter rules:
- the count holds between ticks;
- it steps by exactly one;
- it clears after the period value.

They also check that every flip-flop change while running comes with an interrupt pulse, and that each interrupt lasts a single cycle. Only the bench's scenarios can show that the waveform levels and event spacing match the compare values and the selected prescale. These include the zero duty value at start, the disabled pin, and the state left behind after stopping.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int CNT_W    = 16;
    localparam int SEL_W    = 2;
    localparam int DIV_STEP = 2;
    localparam int PRE_W    = DIV_STEP * ((1 << SEL_W) - 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [SEL_W-1:0] {
        CK_DIV1  = 2'd0,
        CK_DIV4  = 2'd1,
        CK_DIV16 = 2'd2,
        CK_DIV64 = 2'd3
    } cksel_e;

    typedef struct packed {
        logic hit_period;
        logic hit_duty;
    } match_t;

    function automatic logic toggle_req(input match_t m);
        return m.hit_period | m.hit_duty;
    endfunction

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler
    import ppg_pkg::*;
#(
    parameter int SW   = SEL_W,
    parameter int STEP = DIV_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int NSEL = 1 << SW;
    localparam int PW   = STEP * (NSEL - 1);

    logic [PW-1:0] pre_cnt;
    logic [PW-1:0] mask_tab [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_mask
        localparam int SH = g * STEP;
        assign mask_tab[g] = PW'((64'd1 << SH) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) pre_cnt <= '0;
        else             pre_cnt <= pre_cnt + 1'b1;
    end

    assign tick = run && ((pre_cnt & mask_tab[sel]) == mask_tab[sel]);

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter
    import ppg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    output logic [W-1:0] cnt,
    output match_t       hit
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = (cnt == period) ? '0 : cnt + 1'b1;
        hit.hit_period = run && tick && (nxt == period);
        hit.hit_duty   = run && tick && (nxt == duty);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= nxt;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (cnt == $past(cnt)));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && cnt != period) |=> (cnt == $past(cnt) + W'(1)));

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && cnt == period) |=> (cnt == '0));

    // R7
    cnt_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/ppg_outctl.sv
module ppg_outctl
    import ppg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   init_level,
    input  logic   out_en,
    input  match_t hit,
    output logic   pulse_out,
    output logic   irq_duty,
    output logic   irq_period
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst)                  lvl_q <= 1'b0;
        else if (!run)            lvl_q <= init_level;
        else if (toggle_req(hit)) lvl_q <= ~lvl_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            irq_duty   <= 1'b0;
            irq_period <= 1'b0;
        end else begin
            irq_duty   <= hit.hit_duty;
            irq_period <= hit.hit_period;
        end
    end

    assign pulse_out = out_en & lvl_q;

    // R4
    toggle_src_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && lvl_q != $past(lvl_q)) |-> (irq_duty || irq_period));

    // R5
    irq_width_chk: assert property (@(posedge clk) disable iff (rst)
        irq_period |=> !irq_period);

    // R5
    irq_duty_width_chk: assert property (@(posedge clk) disable iff (rst)
        irq_duty |=> !irq_duty);

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int SW   = SEL_W,
    parameter int STEP = DIV_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [SW-1:0] clk_sel,
    input  logic [W-1:0]  period_val,
    input  logic [W-1:0]  duty_val,
    input  logic          init_level,
    input  logic          out_en,
    output logic [W-1:0]  count,
    output logic          pulse_out,
    output logic          irq_duty,
    output logic          irq_period
);
    logic   tick;
    match_t hit;

    ppg_prescaler #(.SW(SW), .STEP(STEP)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (clk_sel),
        .tick (tick)
    );

    ppg_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .period (period_val),
        .duty   (duty_val),
        .cnt    (count),
        .hit    (hit)
    );

    ppg_outctl u_out (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .init_level (init_level),
        .out_en     (out_en),
        .hit        (hit),
        .pulse_out  (pulse_out),
        .irq_duty   (irq_duty),
        .irq_period (irq_period)
    );

    // R8
    pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_en && !$past(out_en) && run) |-> !pulse_out);

endmodule

// File: tb/test_ppg_timer.sv
module test_ppg_timer;

    typedef struct {
        bit    is_per;
        int    cnt;
        bit    pin;
        int    gap;
        string tag_kind;
        string tag_pin;
        string tag_gap;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic [15:0] period_val = 16'd9;
    logic [15:0] duty_val = 16'd3;
    logic        init_level = 1'b0;
    logic        out_en = 1'b0;
    logic [15:0] count;
    logic        pulse_out, irq_duty, irq_period;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    int   last_evt = 0;
    bit   first_evt = 1'b1;
    exp_t q[$];

    ppg_timer i_ppg_timer (
        .clk(clk), .rst(rst), .run(run), .clk_sel(clk_sel),
        .period_val(period_val), .duty_val(duty_val),
        .init_level(init_level), .out_en(out_en),
        .count(count), .pulse_out(pulse_out),
        .irq_duty(irq_duty), .irq_period(irq_period)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "watchdog", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
        if (!rst && (irq_duty || irq_period)) begin
            if (q.size() == 0) begin
                check(1'b0, "R5 unexpected irq", {30'd0, irq_period, irq_duty}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(irq_period == e.is_per && irq_duty == !e.is_per, e.tag_kind,
                      int'(irq_period), int'(e.is_per));
                check(int'(count) == e.cnt, "R2 count at event", int'(count), e.cnt);
                check(pulse_out == e.pin, e.tag_pin, int'(pulse_out), int'(e.pin));
                if (!first_evt && e.gap >= 0)
                    check(cyc - last_evt == e.gap, e.tag_gap, cyc - last_evt, e.gap);
                first_evt = 1'b0;
                last_evt  = cyc;
            end
        end
    end

    task automatic scenario(input int sel, input int p, input int d, input bit init,
                            input bit oe, input int nev);
        int  dv;
        bit  lvl;
        bit  per_next;
        dv = 1 << (2 * sel);
        @(posedge clk); #2;
        clk_sel = 2'(sel); period_val = 16'(p); duty_val = 16'(d);
        init_level = init; out_en = oe;
        @(posedge clk); #2;
        // R7: stopped state follows the new initial level
        @(negedge clk);
        check(pulse_out == (oe & init), "R7 stopped level", int'(pulse_out), int'(oe & init));
        check(count == 16'd0, "R7 stopped count", int'(count), 0);
        lvl = init;
        per_next = (d == 0);
        for (int k = 0; k < nev; k++) begin
            exp_t e;
            lvl = ~lvl;
            e.is_per  = per_next;
            e.cnt     = per_next ? p : d;
            e.pin     = oe & lvl;
            e.gap     = (k == 0) ? -1 : (per_next ? (p - d) * dv : (d + 1) * dv);
            e.tag_kind = (k == 0 && d == 0) ? "R6 first event kind" : "R5 irq kind";
            e.tag_pin  = oe ? "R4 level" : "R8 pin disabled";
            e.tag_gap  = (sel != 0) ? "R3 tick spacing" : "R4 match spacing";
            q.push_back(e);
            per_next = ~per_next;
        end
        first_evt = 1'b1;
        @(posedge clk); #2;
        run = 1'b1;
        for (int w = 0; w < 40000 && q.size() != 0; w++) @(posedge clk);
        check(q.size() == 0, "R5 events missing", q.size(), 0);
        q.delete();
        #2;
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R7: counter cleared, flop reloaded, no interrupt
        check(count == 16'd0, "R7 count after stop", int'(count), 0);
        check(pulse_out == (oe & init), "R7 level after stop", int'(pulse_out), int'(oe & init));
        check(!irq_duty && !irq_period, "R7 irq after stop", int'(irq_duty | irq_period), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(count == 16'd0, "R1 count in reset", int'(count), 0);
        check(pulse_out == 1'b0, "R1 pin in reset", int'(pulse_out), 0);
        check(!irq_duty && !irq_period, "R1 irq in reset", int'(irq_duty | irq_period), 0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        check(count == 16'd0 && !pulse_out && !irq_duty && !irq_period,
              "R1 after reset", int'(count), 0);

        scenario(0, 9, 3, 1'b0, 1'b1, 6);
        scenario(1, 5, 2, 1'b1, 1'b1, 4);
        scenario(0, 4, 0, 1'b0, 1'b1, 4);
        scenario(0, 7, 6, 1'b1, 1'b0, 4);
        scenario(2, 3, 1, 1'b0, 1'b1, 4);
        scenario(3, 2, 1, 1'b1, 1'b1, 3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule